// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Port (Master/Slave)

This block is a synchronous serial port that moves one byte at a time in full duplex. A host reaches it through three byte registers: a control register, a control/status register and a data register. The same block can drive the serial clock as a master or follow a serial clock from another device as a slave. In master mode the serial clock is the system clock divided by a ratio between 4 and 128. The ratio is picked by a three-bit code whose top bit sits in a different field from the lower two. All four combinations of clock idle level and capture phase are supported, and data moves most significant bit first.

The port has four status flags: transfer done, write collision, overrun and mode fault. It raises one interrupt line. The slave-select input can be replaced by a software-held value. A mode fault occurs when a master sees its slave select pulled low. It then drops back to slave mode by itself. The shift sequencing is handled by a two-state machine. ST_IDLE moves to ST_XFER on a master data write or on the first serial clock edge seen by a selected slave. ST_XFER returns to ST_IDLE on the sixteenth clock edge, on an abort (port disabled or mode fault), or when a slave is deselected.

Top module: `spi_port`

## Requirements
- R1: After reset, the control register (address 0), the control/status register (address 1) and the data register (address 2) all read 00h.
- R2: A data-register write in master mode, with the port enabled, sends that byte MSB first while receiving the peer's byte. When the transfer ends, bit 7 of the control/status register (done flag) is set on both master and slave, and a data-register read returns the received byte.
- R3: Control bit 3 sets the idle level of the serial clock, and the master's clock rests there between transfers. Control bit 2 set to 0 captures data on the first clock edge; set to 1 it captures on the second. All four combinations carry data correctly between master and slave.
- R4: In master mode the rate code {control bit 5, control bits 1:0} sets the clock period as follows: 100 gives 4 system clocks, 000 gives 8, 001 gives 16, 110 gives 32, 010 gives 64, 011 gives 128. Codes 101 and 111 also give 128.
- R5: The rate code has no effect on a slave.
- R6: A data-register write while a transfer is in progress sets bit 6 (collision) and is discarded. The byte being shifted is not changed.
- R7: If a transfer completes while the done flag is still set, bit 5 (overrun) is set. The received-byte buffer keeps its earlier content.
- R8: Reading the control/status register, then accessing the data register, clears bits 7 to 4. Reading the control/status register alone clears nothing.
- R9: If the port is enabled in master mode (bit 4) and its internal slave select is low, the port clears bit 4 and sets bit 4 of the control/status register (mode fault).
- R10: When control/status bit 1 is set, bit 0 replaces the slave-select pin as the internal select. Set selects nothing; clear selects.
- R11: When control/status bit 2 is set, the serial data output enable is held low.
- R12: Clearing control bit 6 (enable) aborts any transfer and returns the serial clock to its idle level, and no done flag follows.
- R13: The interrupt line is high when control bit 7 is set and either the done flag or the mode-fault flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Register select: 0 control, 1 control/status, 2 data |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives flag clearing) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock from a master (slave mode) |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Master-to-slave data in (slave mode) |
| mosi_o | output | 1 | Master-to-slave data out (master mode) |
| mosi_oe | output | 1 | Enable for mosi_o |
| miso_i | input | 1 | Slave-to-master data in (master mode) |
| miso_o | output | 1 | Slave-to-master data out (slave mode) |
| miso_oe | output | 1 | Enable for miso_o |
| ss_n_i | input | 1 | Slave-select pin, active low |

## Verification
Two copies of the port are wired back to back, so a phase error shows up as a byte shifted by one bit or with the wrong bit order in one direction. The bench measures the clock's high time for every rate code, because the code is not in numeric order and a plain binary decode would give the wrong period. The bench also writes to the data register in mid-transfer and lets a second byte land on an unread flag. A design that let the late write through would corrupt the outgoing byte. A design that overwrote the buffer on overrun would return the newer byte. The mode-fault, software-select and output-disable cases each look at a port-level result: the master bit reads back cleared, a deselected slave sets no flag and drives nothing, and a disabled output shows up as all-ones at the receiver.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
    localparam int BYTE_W   = 8;
    localparam int DIV_MAX  = 128;
    localparam int HALF_W   = $clog2(DIV_MAX / 2);

    typedef enum logic {ST_IDLE, ST_XFER} eng_state_t;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;

    // half period of the serial clock, minus one, in system clocks
    function automatic logic [HALF_W-1:0] half_minus1(input logic [2:0] code);
        logic [HALF_W-1:0] r;
        case (code)
            3'b100:  r = HALF_W'(1);
            3'b000:  r = HALF_W'(3);
            3'b001:  r = HALF_W'(7);
            3'b110:  r = HALF_W'(15);
            3'b010:  r = HALF_W'(31);
            default: r = HALF_W'(63);
        endcase
        return r;
    endfunction
endpackage

// File: rtl/spi_port_clkgen.sv
module spi_port_clkgen #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             tick
);
    logic [CNT_W-1:0] cnt;

    assign tick = run && (cnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/spi_port_engine.sv
module spi_port_engine
    import spi_port_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          abort,
    input  logic          master,
    input  logic          cpol,
    input  logic          cpha,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          start,
    input  logic          tick,
    input  logic          sel,
    input  logic          sck_i,
    input  logic          sdi,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rx_byte,
    output logic          sdo,
    output logic          sck_o
);
    localparam int EDGES = 2 * DW;
    localparam int EC_W  = $clog2(EDGES);

    eng_state_t      state, nxt;
    logic [EC_W-1:0] cnt;
    logic [DW-1:0]   shreg;
    logic            out_bit, sck_r, sck_q, done_r;
    logic            slave_edge, edge_ev, is_cap, last, desel;

    assign slave_edge = !master && sel && (sck_i != sck_q);
    assign edge_ev    = master ? (state == ST_XFER && tick) : slave_edge;
    assign is_cap     = (cnt[0] == cpha);
    assign last       = (cnt == EC_W'(EDGES - 1));
    assign desel      = (state == ST_XFER) && !master && !sel;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (!abort && ((master && start) || slave_edge)) nxt = ST_XFER;
            ST_XFER: if (abort || desel || (edge_ev && last))         nxt = ST_IDLE;
        endcase
    end

    // shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            shreg   <= '0;
            out_bit <= 1'b0;
            sck_r   <= 1'b0;
            sck_q   <= 1'b0;
            done_r  <= 1'b0;
        end else begin
            sck_q  <= sck_i;
            done_r <= 1'b0;
            if (state == ST_IDLE && load) begin
                shreg   <= load_data;
                out_bit <= load_data[DW-1];
                sck_r   <= cpol;
                cnt     <= '0;
            end else if (abort || desel) begin
                cnt     <= '0;
                sck_r   <= cpol;
                out_bit <= shreg[DW-1];
            end else if (edge_ev) begin
                if (master) sck_r <= ~sck_r;
                if (is_cap) shreg   <= {shreg[DW-2:0], sdi};
                else        out_bit <= shreg[DW-1];
                cnt <= last ? '0 : cnt + 1'b1;
                if (last) done_r <= 1'b1;
            end else if (state == ST_IDLE) begin
                sck_r <= cpol;
            end
        end
    end

    // outputs
    always_comb begin
        busy    = (state == ST_XFER);
        done    = done_r;
        rx_byte = shreg;
        sdo     = out_bit;
        sck_o   = sck_r;
    end
endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] addr,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       irq,
    input  logic       sck_i,
    output logic       sck_o,
    output logic       sck_oe,
    input  logic       mosi_i,
    output logic       mosi_o,
    output logic       mosi_oe,
    input  logic       miso_i,
    output logic       miso_o,
    output logic       miso_oe,
    input  logic       ss_n_i
);
    logic spie, spe, spr2, mstr, cpol, cpha;
    logic [1:0] spr;
    logic sod, ssm, ssi;
    logic spif, wcol, ovr, modf, clr_armed;
    logic [BYTE_W-1:0] rxbuf, rx_byte;
    logic [HALF_W-1:0] half;
    logic eng_busy, eng_done, tick, sdo;
    logic wr_ctrl, wr_stat, wr_data, rd_stat, dr_access, flag_clr;
    logic ss_int, modf_ev, sel, load, start, abort;

    assign wr_ctrl   = wr_en && addr == A_CTRL;
    assign wr_stat   = wr_en && addr == A_STAT;
    assign wr_data   = wr_en && addr == A_DATA;
    assign rd_stat   = rd_en && addr == A_STAT;
    assign dr_access = (wr_en || rd_en) && addr == A_DATA;
    assign flag_clr  = clr_armed && dr_access;

    assign ss_int  = ssm ? ssi : ss_n_i;
    assign modf_ev = spe && mstr && !ss_int;
    assign sel     = spe && !mstr && !ss_int;
    assign load    = wr_data && !eng_busy;
    assign start   = load && spe && mstr && !modf_ev;
    assign abort   = !spe || modf_ev;
    assign half    = half_minus1({spr2, spr});

    spi_port_clkgen #(.CNT_W(HALF_W)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .run(eng_busy && mstr), .limit(half), .tick(tick)
    );

    spi_port_engine #(.DW(BYTE_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .abort(abort), .master(mstr), .cpol(cpol), .cpha(cpha),
        .load(load), .load_data(wdata), .start(start), .tick(tick), .sel(sel),
        .sck_i(sck_i), .sdi(mstr ? miso_i : mosi_i), .busy(eng_busy), .done(eng_done),
        .rx_byte(rx_byte), .sdo(sdo), .sck_o(sck_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {spie, spe, spr2, mstr, cpol, cpha, spr} <= '0;
            {sod, ssm, ssi}                          <= '0;
            {spif, wcol, ovr, modf}                  <= '0;
            clr_armed <= 1'b0;
            rxbuf     <= '0;
        end else begin
            if (wr_ctrl) {spie, spe, spr2, mstr, cpol, cpha, spr} <= wdata;
            if (modf_ev) begin
                mstr <= 1'b0;
                modf <= 1'b1;
            end
            if (wr_stat) {sod, ssm, ssi} <= wdata[2:0];
            if (rd_stat)        clr_armed <= 1'b1;
            else if (dr_access) clr_armed <= 1'b0;
            if (flag_clr) begin
                spif <= 1'b0;
                wcol <= 1'b0;
                ovr  <= 1'b0;
                if (!modf_ev) modf <= 1'b0;
            end
            if (eng_done) begin
                if (spif && !flag_clr) ovr <= 1'b1;
                else begin
                    spif  <= 1'b1;
                    rxbuf <= rx_byte;
                end
            end
            if (wr_data && eng_busy) wcol <= 1'b1;
        end
    end

    always_comb begin
        case (addr)
            A_CTRL:  rdata = {spie, spe, spr2, mstr, cpol, cpha, spr};
            A_STAT:  rdata = {spif, wcol, ovr, modf, 1'b0, sod, ssm, ssi};
            A_DATA:  rdata = rxbuf;
            default: rdata = '0;
        endcase
        irq     = spie && (spif || modf);
        sck_oe  = spe && mstr;
        mosi_o  = sdo;
        mosi_oe = spe && mstr && !sod;
        miso_o  = sdo;
        miso_oe = sel && !sod;
    end
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       spe,
    input logic       mstr,
    input logic       cpol,
    input logic       ssm,
    input logic       ssi,
    input logic       ss_n_i,
    input logic       wr_en,
    input logic [1:0] addr,
    input logic       busy,
    input logic       done,
    input logic       spif,
    input logic       modf,
    input logic       wcol,
    input logic       sck_o
);
    AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        spe && mstr && !busy && $stable(cpol) |-> sck_o == cpol); // R3

    AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> spif); // R2

    AST_WCOL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == 2'd2 && busy |=> wcol); // R6

    AST_MODF_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        spe && mstr && !(ssm ? ssi : ss_n_i) |=> !mstr && modf); // R9

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !spe |=> !busy); // R12
endmodule

bind spi_port spi_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .spe(spe), .mstr(mstr), .cpol(cpol), .ssm(ssm),
    .ssi(ssi), .ss_n_i(ss_n_i), .wr_en(wr_en), .addr(addr), .busy(eng_busy),
    .done(eng_done), .spif(spif), .modf(modf), .wcol(wcol), .sck_o(sck_o)
);

// File: tb/test_spi_port.sv
`timescale 1ns/1ps
module test_spi_port;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [1:0] m_addr = '0, s_addr = '0;
    logic m_wr = 0, m_rd = 0, s_wr = 0, s_rd = 0;
    logic [7:0] m_wdata = '0, s_wdata = '0;
    logic [7:0] m_rdata, s_rdata;
    logic m_irq, s_irq;
    logic m_sck_o, m_sck_oe, m_mosi_o, m_mosi_oe, m_miso_o, m_miso_oe;
    logic s_sck_o, s_sck_oe, s_mosi_o, s_mosi_oe, s_miso_o, s_miso_oe;
    logic m_ss_n = 1'b1, ss_n = 1'b1;
    logic line_mosi, line_miso;

    assign line_mosi = m_mosi_oe ? m_mosi_o : 1'b1;
    assign line_miso = s_miso_oe ? s_miso_o : 1'b1;

    spi_port i_spi_port (
        .clk(clk), .rst_n(rst_n), .addr(m_addr), .wr_en(m_wr), .rd_en(m_rd),
        .wdata(m_wdata), .rdata(m_rdata), .irq(m_irq), .sck_i(1'b0),
        .sck_o(m_sck_o), .sck_oe(m_sck_oe), .mosi_i(1'b1), .mosi_o(m_mosi_o),
        .mosi_oe(m_mosi_oe), .miso_i(line_miso), .miso_o(m_miso_o),
        .miso_oe(m_miso_oe), .ss_n_i(m_ss_n)
    );

    spi_port i_spi_port_s (
        .clk(clk), .rst_n(rst_n), .addr(s_addr), .wr_en(s_wr), .rd_en(s_rd),
        .wdata(s_wdata), .rdata(s_rdata), .irq(s_irq), .sck_i(m_sck_o),
        .sck_o(s_sck_o), .sck_oe(s_sck_oe), .mosi_i(line_mosi), .mosi_o(s_mosi_o),
        .mosi_oe(s_mosi_oe), .miso_i(1'b1), .miso_o(s_miso_o),
        .miso_oe(s_miso_oe), .ss_n_i(ss_n)
    );

    int checks = 0, fails = 0, cyc = 0;

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input bit slv, input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        if (slv) begin s_addr = a; s_wdata = d; s_wr = 1; end
        else     begin m_addr = a; m_wdata = d; m_wr = 1; end
        @(negedge clk);
        s_wr = 0; m_wr = 0;
    endtask

    task automatic bus_rd(input bit slv, input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        if (slv) begin s_addr = a; s_rd = 1; end
        else     begin m_addr = a; m_rd = 1; end
        #1 d = slv ? s_rdata : m_rdata;
        @(negedge clk);
        s_rd = 0; m_rd = 0;
    endtask

    task automatic wait_master(input bit ie);
        logic [7:0] v = 8'h00;
        for (int i = 0; i < 2000; i++) begin
            bus_rd(0, 2'd1, v);
            if (v[7]) break;
        end
        check("R2 master done flag", v[7], 1);
        check("R13 irq on done", m_irq, ie);
    endtask

    task automatic run_xfer(input logic [7:0] mcr, scr, mb, sb, input bit ss_lvl,
                            input bit clr_s, output logic [7:0] mrx, srx, scsr);
        ss_n = 1'b1;
        bus_wr(0, 2'd0, mcr);
        bus_wr(1, 2'd0, scr);
        bus_wr(1, 2'd2, sb);
        ss_n = ss_lvl;
        bus_wr(0, 2'd2, mb);
        wait_master(mcr[7]);
        bus_rd(0, 2'd2, mrx);
        repeat (3) @(negedge clk);
        srx = 8'h00; scsr = 8'h00;
        if (clr_s) begin
            bus_rd(1, 2'd1, scsr);
            bus_rd(1, 2'd2, srx);
        end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int a = 0; a < 3; a++) begin
            bus_rd(0, 2'(a), v);
            check("R1 reset value", v, 0);
        end
    endtask

    task automatic t_modes();
        logic [7:0] mrx, srx, scsr, mcr, scr, mb, sb;
        for (int m = 0; m < 4; m++) begin
            mcr = 8'hD0 | 8'(m << 2);
            scr = 8'h40 | 8'(m << 2) | (8'(m * 8'h11) & 8'h23); // R5 slave rate bits vary
            mb  = 8'hA5 ^ 8'(m * 8'h37);
            sb  = 8'h3C ^ 8'(m * 8'h59);
            run_xfer(mcr, scr, mb, sb, 1'b0, 1'b1, mrx, srx, scsr);
            check("R3 master got slave byte", mrx, sb);
            check("R3 slave got master byte", srx, mb);
            check("R2 slave done flag", scsr[7], 1);
            check("R3 sck idle level", m_sck_o, m >> 1);
            check("R13 irq cleared", m_irq, 0);
        end
    endtask

    task automatic t_rates();
        logic [2:0] codes [6] = '{3'b100, 3'b000, 3'b001, 3'b110, 3'b010, 3'b011};
        int divs [6] = '{4, 8, 16, 32, 64, 128};
        logic [7:0] v;
        ss_n = 1'b1;
        for (int k = 0; k < 6; k++) begin
            int hi = 0, g = 0;
            bus_wr(0, 2'd0, 8'h50 | {2'b00, codes[k][2], 3'b000, codes[k][1:0]});
            bus_wr(0, 2'd2, 8'h3C);
            while (m_sck_o == 1'b0 && g < 500) begin @(negedge clk); g++; end
            while (m_sck_o == 1'b1 && hi < 500) begin @(negedge clk); hi++; end
            check("R4 sck half period", hi, divs[k] / 2);
            wait_master(1'b0);
            bus_rd(0, 2'd2, v);
            check("R4 pulled-up receive", v, 8'hFF);
        end
    endtask

    task automatic t_wcol();
        logic [7:0] v;
        ss_n = 1'b1;
        bus_wr(0, 2'd0, 8'h50);
        bus_wr(1, 2'd0, 8'h40);
        bus_wr(1, 2'd2, 8'h5A);
        ss_n = 1'b0;
        bus_wr(0, 2'd2, 8'hC3);
        bus_wr(0, 2'd2, 8'h00);
        wait_master(1'b0);
        bus_rd(0, 2'd1, v);
        check("R6 collision flag, R8 kept by status read", v, 8'hC0);
        bus_rd(0, 2'd2, v);
        check("R6 master receive", v, 8'h5A);
        bus_rd(0, 2'd1, v);
        check("R8 flags cleared", v, 8'h00);
        bus_rd(1, 2'd1, v);
        bus_rd(1, 2'd2, v);
        check("R6 late write discarded", v, 8'hC3);
    endtask

    task automatic t_ovr();
        logic [7:0] mrx, srx, scsr, v;
        run_xfer(8'h50, 8'h40, 8'h11, 8'h22, 1'b0, 1'b0, mrx, srx, scsr);
        run_xfer(8'h50, 8'h40, 8'h33, 8'h44, 1'b0, 1'b0, mrx, srx, scsr);
        bus_rd(1, 2'd1, v);
        check("R7 overrun flag", v, 8'hA0);
        bus_rd(1, 2'd2, v);
        check("R7 buffer kept", v, 8'h11);
    endtask

    task automatic t_modf();
        logic [7:0] v;
        ss_n = 1'b1;
        bus_wr(0, 2'd0, 8'hD0);
        m_ss_n = 1'b0;
        repeat (2) @(negedge clk);
        m_ss_n = 1'b1;
        bus_rd(0, 2'd0, v);
        check("R9 master bit cleared", v, 8'hC0);
        bus_rd(0, 2'd1, v);
        check("R9 mode fault flag", v, 8'h10);
        check("R13 irq on fault", m_irq, 1);
        bus_rd(0, 2'd2, v);
        bus_rd(0, 2'd1, v);
        check("R8 fault cleared", v, 8'h00);
    endtask

    task automatic t_ssm_sod();
        logic [7:0] mrx, srx, scsr, v;
        bus_wr(1, 2'd1, 8'h02);
        run_xfer(8'h50, 8'h40, 8'h96, 8'h69, 1'b1, 1'b1, mrx, srx, scsr);
        check("R10 soft select on", srx, 8'h96);
        bus_wr(1, 2'd1, 8'h03);
        run_xfer(8'h50, 8'h40, 8'h0F, 8'h00, 1'b0, 1'b0, mrx, srx, scsr);
        check("R10 soft deselect miso_oe", s_miso_oe, 0);
        check("R10 master sees idle line", mrx, 8'hFF);
        bus_rd(1, 2'd1, v);
        check("R10 slave no done flag", v, 8'h03);
        bus_wr(1, 2'd1, 8'h00);
        bus_wr(0, 2'd1, 8'h04);
        run_xfer(8'h50, 8'h40, 8'h12, 8'h34, 1'b0, 1'b1, mrx, srx, scsr);
        check("R11 output disabled", m_mosi_oe, 0);
        check("R11 slave sees idle line", srx, 8'hFF);
        bus_wr(0, 2'd1, 8'h00);
    endtask

    task automatic t_disable();
        logic [7:0] v;
        ss_n = 1'b1;
        bus_wr(0, 2'd0, 8'h5B);
        bus_wr(0, 2'd2, 8'h81);
        repeat (100) @(negedge clk);
        bus_wr(0, 2'd0, 8'h1B);
        repeat (3) @(negedge clk);
        check("R12 sck back to idle", m_sck_o, 1);
        repeat (1200) @(negedge clk);
        bus_rd(0, 2'd1, v);
        check("R12 no done after abort", v, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_modes();
        t_rates();
        t_wcol();
        t_ovr();
        t_modf();
        t_ssm_sod();
        t_disable();
        summary();
    end
endmodule